// File: doc/BRIEF.md
# Doorbell Interrupt Collector

This block gathers message-signalled interrupts that arrive as ordinary memory writes and turns them into one level-sensitive interrupt line. Software uses a 32-bit register port to program a 64-bit doorbell address, which it writes as two word halves, and a bank of 32 vectors. Each vector has an enable bit, a mask bit and a status bit. A device signals vector `v` by writing the value `v` to the doorbell address. The block records that event in the status bank and raises the line when an unmasked vector is pending.

The doorbell window is a single 4-byte location. It only responds while the enable register is non-zero. Its position is taken from the doorbell address register at the moment the enable register is written. Software acknowledges vectors by writing a pattern that is XORed into status. The line falls only when such a write leaves every status bit clear, whatever the mask holds.

Top module: `msi_doorbell_irq`

## Requirements
- R1: After reset the doorbell address, enable, mask and status registers read zero and `irqOut` is low.
- R2: Register offset 0x820 holds doorbell address bits [31:0] and offset 0x824 holds bits [63:32]. A write to either offset replaces only that half and leaves the other half unchanged. Both halves read back their current value.
- R3: The enable register at 0x828 and the mask register at 0x82C read back the last value written to them. Unused offsets read zero.
- R4: A doorbell hit with data value `d` sets status bit `d[4:0]`, but only if enable bit `d[4:0]` is set. Data bits above bit 4 play no part in the selection.
- R5: One cycle after a doorbell hit, `irqOut` is high if (status AND NOT mask) is non-zero. Otherwise it keeps its previous level.
- R6: A register write to status at 0x830 XORs the written value into status. The result is visible on the next cycle.
- R7: `irqOut` falls only on the cycle after a status write that leaves all 32 status bits zero. A write that leaves any bit set, masked or not, keeps it high.
- R8: A mask write alone never changes `irqOut`.
- R9: The window is armed only when the last value written to the enable register was non-zero. Its address is latched from the doorbell address register when the enable register is written. Later address writes do not move the window until the enable register is written again.
- R10: An inbound write counts as a doorbell hit only if its address equals the latched window address exactly and all four byte enables are set.
- R11: When a status write and a doorbell hit land in the same cycle, the XOR is applied first and the doorbell bit is ORed into the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | REG_AW | Register offset for writes and for readback |
| regWrData | input | DATA_W | Register write data |
| regRdData | output | DATA_W | Combinational readback of the register at `regAddr` |
| inWrEn | input | 1 | Inbound memory write valid |
| inWrAddr | input | 2*DATA_W | Inbound write address |
| inWrData | input | DATA_W | Inbound write data, little-endian |
| inWrBe | input | DATA_W/8 | Inbound byte enables |
| irqOut | output | 1 | Level interrupt line |

## Verification
The bench checks a window that stays at its latched address after the address register changes. A design that tracked the address register live would accept writes at the new address and ignore the old one. It checks an acknowledge that clears only some pending bits. A design that dropped the line on masked status alone, or on any status write, would fall too early. It sends doorbells whose upper data bits are set, doorbells with partial byte enables, and doorbells to a disabled vector. A design that decoded too wide or too loosely would set status bits that should stay clear. It also lands a status write and a doorbell in the same cycle. The wrong ordering would lose the new vector or undo the acknowledge.

// File: rtl/msi_cap_pkg.sv
package msi_cap_pkg;

  // Register offsets; software depends on these positions.
  localparam logic [11:0] OFS_ADDR_LO = 12'h820;
  localparam logic [11:0] OFS_ADDR_HI = 12'h824;
  localparam logic [11:0] OFS_ENABLE  = 12'h828;
  localparam logic [11:0] OFS_MASK    = 12'h82C;
  localparam logic [11:0] OFS_STATUS  = 12'h830;

  // Strobes from the control decode to the datapath.
  typedef struct packed {
    logic setAddrLo;
    logic setAddrHi;
    logic setEnable;
    logic setMask;
    logic toggleStatus;
    logic ringHit;
  } ctlStrobe_t;

endpackage

// File: rtl/msi_cap_ctrl.sv
module msi_cap_ctrl
  import msi_cap_pkg::*;
#(
  parameter int REG_AW = 12,
  parameter int DATA_W = 32,
  parameter int BUS_AW = 64
) (
  input  logic              regWrEn,
  input  logic [REG_AW-1:0] regAddr,
  input  logic              inWrEn,
  input  logic [BUS_AW-1:0] inWrAddr,
  input  logic [DATA_W/8-1:0] inWrBe,
  input  logic              winOn,
  input  logic [BUS_AW-1:0] winBase,
  output ctlStrobe_t        strb
);

  logic fullWord;
  logic addrMatch;

  assign fullWord  = &inWrBe;
  assign addrMatch = (inWrAddr == winBase);

  always_comb begin
    strb              = '0;
    strb.setAddrLo    = regWrEn && (regAddr == REG_AW'(OFS_ADDR_LO));
    strb.setAddrHi    = regWrEn && (regAddr == REG_AW'(OFS_ADDR_HI));
    strb.setEnable    = regWrEn && (regAddr == REG_AW'(OFS_ENABLE));
    strb.setMask      = regWrEn && (regAddr == REG_AW'(OFS_MASK));
    strb.toggleStatus = regWrEn && (regAddr == REG_AW'(OFS_STATUS));
    strb.ringHit      = inWrEn && winOn && addrMatch && fullWord;
  end

endmodule

// File: rtl/msi_cap_datapath.sv
module msi_cap_datapath
  import msi_cap_pkg::*;
#(
  parameter int REG_AW = 12,
  parameter int DATA_W = 32,
  parameter int BUS_AW = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strb,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  input  logic [DATA_W-1:0] inWrData,
  output logic [DATA_W-1:0] regRdData,
  output logic              winOn,
  output logic [BUS_AW-1:0] winBase,
  output logic              irqOut
);

  localparam int VEC_W = $clog2(DATA_W);

  logic [BUS_AW-1:0] ringAddr;
  logic [DATA_W-1:0] enReg;
  logic [DATA_W-1:0] maskReg;
  logic [DATA_W-1:0] statReg;
  logic [DATA_W-1:0] statNext;
  logic [DATA_W-1:0] ringBits;
  logic [VEC_W-1:0]  vecIdx;
  logic              irqReg;
  logic              irqNext;

  assign vecIdx = inWrData[VEC_W-1:0];

  // One slice per vector: acknowledge toggle first, then the doorbell sets its bit.
  for (genvar i = 0; i < DATA_W; i++) begin : g_vec
    logic afterTog;
    assign ringBits[i] = strb.ringHit && (vecIdx == VEC_W'(i)) && enReg[i];
    assign afterTog    = strb.toggleStatus ? (statReg[i] ^ regWrData[i]) : statReg[i];
    assign statNext[i] = afterTog | ringBits[i];
  end

  always_comb begin
    irqNext = irqReg;
    if (strb.ringHit && (|(statNext & ~maskReg))) begin
      irqNext = 1'b1;
    end else if (strb.toggleStatus && (statNext == '0)) begin
      irqNext = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ringAddr <= '0;
      enReg    <= '0;
      maskReg  <= '0;
      statReg  <= '0;
      irqReg   <= 1'b0;
      winOn    <= 1'b0;
      winBase  <= '0;
    end else begin
      if (strb.setAddrLo) ringAddr[DATA_W-1:0]      <= regWrData;
      if (strb.setAddrHi) ringAddr[BUS_AW-1:DATA_W] <= regWrData;
      if (strb.setEnable) begin
        enReg   <= regWrData;
        winOn   <= |regWrData;
        winBase <= ringAddr;
      end
      if (strb.setMask) maskReg <= regWrData;
      statReg <= statNext;
      irqReg  <= irqNext;
    end
  end

  always_comb begin
    case (regAddr)
      REG_AW'(OFS_ADDR_LO): regRdData = ringAddr[DATA_W-1:0];
      REG_AW'(OFS_ADDR_HI): regRdData = ringAddr[BUS_AW-1:DATA_W];
      REG_AW'(OFS_ENABLE):  regRdData = enReg;
      REG_AW'(OFS_MASK):    regRdData = maskReg;
      REG_AW'(OFS_STATUS):  regRdData = statReg;
      default:              regRdData = '0;
    endcase
  end

  assign irqOut = irqReg;

endmodule

// File: rtl/msi_doorbell_irq.sv
module msi_doorbell_irq
  import msi_cap_pkg::*;
#(
  parameter int REG_AW = 12,
  parameter int DATA_W = 32
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  regWrEn,
  input  logic [REG_AW-1:0]     regAddr,
  input  logic [DATA_W-1:0]     regWrData,
  output logic [DATA_W-1:0]     regRdData,
  input  logic                  inWrEn,
  input  logic [2*DATA_W-1:0]   inWrAddr,
  input  logic [DATA_W-1:0]     inWrData,
  input  logic [DATA_W/8-1:0]   inWrBe,
  output logic                  irqOut
);

  localparam int BUS_AW = 2 * DATA_W;

  ctlStrobe_t        strb;
  logic              winOn;
  logic [BUS_AW-1:0] winBase;

  msi_cap_ctrl #(.REG_AW(REG_AW), .DATA_W(DATA_W), .BUS_AW(BUS_AW)) ctrl_i (
    .regWrEn  (regWrEn),
    .regAddr  (regAddr),
    .inWrEn   (inWrEn),
    .inWrAddr (inWrAddr),
    .inWrBe   (inWrBe),
    .winOn    (winOn),
    .winBase  (winBase),
    .strb     (strb)
  );

  msi_cap_datapath #(.REG_AW(REG_AW), .DATA_W(DATA_W), .BUS_AW(BUS_AW)) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .inWrData  (inWrData),
    .regRdData (regRdData),
    .winOn     (winOn),
    .winBase   (winBase),
    .irqOut    (irqOut)
  );

endmodule

// File: rtl/msi_cap_chk.sv
module msi_cap_chk
  import msi_cap_pkg::*;
#(
  parameter int REG_AW = 12,
  parameter int DATA_W = 32
) (
  input logic                clk,
  input logic                rstN,
  input logic                regWrEn,
  input logic [REG_AW-1:0]   regAddr,
  input logic [DATA_W-1:0]   regWrData,
  input logic [DATA_W-1:0]   regRdData,
  input logic                inWrEn,
  input logic                irqOut
);

  logic stWr;
  logic maskWr;
  assign stWr   = regWrEn && (regAddr == REG_AW'(OFS_STATUS));
  assign maskWr = regWrEn && (regAddr == REG_AW'(OFS_MASK));

  // R1: reset drives the line low
  p_reset_low_r1: assert property (@(posedge clk) !rstN |=> !irqOut);

  // R5: the line only rises after an inbound write
  p_rise_needs_ring_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqOut) |-> $past(inWrEn));

  // R7: the line only falls after a status write
  p_fall_needs_ack_r7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(irqOut) |-> $past(stWr));

  // R8: a lone mask write keeps the line level
  p_mask_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    (maskWr && !inWrEn) |=> $stable(irqOut));

  // R6: status readback after a lone acknowledge equals old XOR written
  p_status_xor_r6: assert property (@(posedge clk) disable iff (!rstN)
    (stWr && !inWrEn) ##1 (regAddr == REG_AW'(OFS_STATUS)) |->
      regRdData == $past(regRdData ^ regWrData));

  // R9: with enable reading zero, an inbound write cannot raise the line
  p_disarmed_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == REG_AW'(OFS_ENABLE) && regRdData == '0 && !regWrEn && !irqOut) |=> !irqOut);

endmodule

bind msi_doorbell_irq msi_cap_chk #(.REG_AW(REG_AW), .DATA_W(DATA_W)) chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .regWrEn   (regWrEn),
  .regAddr   (regAddr),
  .regWrData (regWrData),
  .regRdData (regRdData),
  .inWrEn    (inWrEn),
  .irqOut    (irqOut)
);

// File: tb/msi_doorbell_irq_tb.sv
module msi_doorbell_irq_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [11:0] regAddr = 12'h0;
  logic [31:0] regWrData = 32'h0;
  logic [31:0] regRdData;
  logic        inWrEn = 1'b0;
  logic [63:0] inWrAddr = 64'h0;
  logic [31:0] inWrData = 32'h0;
  logic [3:0]  inWrBe = 4'h0;
  logic        irqOut;

  int    nChecks = 0;
  int    nFails = 0;
  bit    running = 1'b0;
  bit    finished = 1'b0;
  string curReq = "R1";

  always #10 clk = ~clk;

  msi_doorbell_irq dut_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .inWrEn(inWrEn),
    .inWrAddr(inWrAddr), .inWrData(inWrData), .inWrBe(inWrBe), .irqOut(irqOut)
  );

  // Behavioural reference model
  logic [63:0] mAddr = 0, mWinBase = 0, oldAddr;
  logic [31:0] mEn = 0, mMask = 0, mStat = 0, s;
  bit          mIrq = 0, mWinOn = 0, hit, ack;
  int          idx;

  always @(posedge clk) begin
    if (!rstN) begin
      mAddr = 0; mWinBase = 0; mEn = 0; mMask = 0; mStat = 0; mIrq = 0; mWinOn = 0;
    end else begin
      hit = inWrEn && mWinOn && (inWrAddr == mWinBase) && (inWrBe == 4'hF);
      ack = regWrEn && (regAddr == 12'h830);
      idx = int'(inWrData % 32);
      s = mStat;
      if (ack) s = s ^ regWrData;
      if (hit && mEn[idx]) s[idx] = 1'b1;
      if (hit && ((s & ~mMask) != 0)) mIrq = 1;
      else if (ack && s == 0) mIrq = 0;
      oldAddr = mAddr;
      if (regWrEn) begin
        if (regAddr == 12'h820) mAddr[31:0] = regWrData;
        if (regAddr == 12'h824) mAddr[63:32] = regWrData;
        if (regAddr == 12'h828) begin mEn = regWrData; mWinOn = regWrData != 0; mWinBase = oldAddr; end
        if (regAddr == 12'h82C) mMask = regWrData;
      end
      mStat = s;
    end
  end

  function automatic logic [31:0] modelRead(logic [11:0] a);
    case (a)
      12'h820: return mAddr[31:0];
      12'h824: return mAddr[63:32];
      12'h828: return mEn;
      12'h82C: return mMask;
      12'h830: return mStat;
      default: return 32'h0;
    endcase
  endfunction

  task automatic expect32(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // Called at a falling edge: compare every output against the model.
  task automatic autoCompare;
    if (running) begin
      expect32({curReq, " irqOut"}, {31'h0, irqOut}, {31'h0, mIrq});
      expect32({curReq, " readback"}, regRdData, modelRead(regAddr));
    end
  endtask

  task automatic tick;
    @(negedge clk);
    autoCompare();
  endtask

  task automatic regWr(logic [11:0] a, logic [31:0] d);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    tick();
    regWrEn = 1'b0;
  endtask

  task automatic ring(logic [63:0] a, logic [31:0] d, logic [3:0] be);
    inWrAddr = a; inWrData = d; inWrBe = be; inWrEn = 1'b1;
    tick();
    inWrEn = 1'b0;
  endtask

  task automatic readChk(string req, logic [11:0] a, logic [31:0] exp);
    regAddr = a;
    #1;
    expect32(req, regRdData, exp);
  endtask

  task automatic irqChk(string req, bit exp);
    expect32(req, {31'h0, irqOut}, {31'h0, exp});
  endtask

  localparam logic [63:0] BASE_A = 64'h0000_0001_2000_0080;
  localparam logic [63:0] BASE_B = 64'h0000_0001_3000_0000;

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    running = 1'b1;
    tick();

    curReq = "R1";
    readChk("R1 addr lo", 12'h820, 0);
    readChk("R1 addr hi", 12'h824, 0);
    readChk("R1 enable", 12'h828, 0);
    readChk("R1 mask", 12'h82C, 0);
    readChk("R1 status", 12'h830, 0);
    irqChk("R1 irq", 0);

    curReq = "R2";
    regWr(12'h820, 32'h1000_0040);
    regWr(12'h824, 32'h0000_0001);
    readChk("R2 lo", 12'h820, 32'h1000_0040);
    regWr(12'h820, 32'h2000_0080);
    readChk("R2 hi kept", 12'h824, 32'h0000_0001);
    readChk("R2 lo new", 12'h820, 32'h2000_0080);

    curReq = "R3";
    regWr(12'h828, 32'hFFFF_FFFF);
    readChk("R3 enable", 12'h828, 32'hFFFF_FFFF);
    regWr(12'h82C, 32'h0000_0004);
    readChk("R3 mask", 12'h82C, 32'h0000_0004);
    readChk("R3 unused", 12'h834, 0);

    curReq = "R4";
    regAddr = 12'h830;
    ring(BASE_A, 32'd3, 4'hF);
    irqChk("R5 unmasked rise", 1);
    ring(BASE_A, 32'h0000_0025, 4'hF);
    readChk("R4 upper data bits ignored", 12'h830, 32'h0000_0028);

    curReq = "R7";
    regWr(12'h830, 32'h0000_0008);
    readChk("R6 xor partial", 12'h830, 32'h0000_0020);
    irqChk("R7 partial clear keeps line", 1);
    regWr(12'h830, 32'h0000_0020);
    irqChk("R7 full clear drops line", 0);

    curReq = "R5";
    regAddr = 12'h830;
    ring(BASE_A, 32'd2, 4'hF);
    irqChk("R5 masked stays low", 0);
    curReq = "R8";
    regWr(12'h82C, 32'h0);
    irqChk("R8 mask write no effect", 0);
    curReq = "R5";
    ring(BASE_A, 32'd31, 4'hF);
    irqChk("R5 rise with pending after unmask", 1);
    curReq = "R7";
    regWr(12'h830, 32'h0000_0004);
    irqChk("R7 masked bit still pending", 1);
    curReq = "R8";
    regWr(12'h82C, 32'hFFFF_FFFF);
    irqChk("R8 masking keeps line high", 1);
    curReq = "R7";
    regWr(12'h830, 32'h8000_0000);
    irqChk("R7 line low after last bit", 0);
    regWr(12'h82C, 32'h0);

    curReq = "R4";
    regWr(12'h828, 32'hFFFF_FFF0);
    regAddr = 12'h830;
    ring(BASE_A, 32'd1, 4'hF);
    readChk("R4 disabled vector", 12'h830, 0);

    curReq = "R10";
    ring(BASE_A + 64'd4, 32'd6, 4'hF);
    ring(BASE_A, 32'd6, 4'h3);
    readChk("R10 near miss and partial", 12'h830, 0);
    irqChk("R10 line low", 0);

    curReq = "R9";
    regWr(12'h824, 32'h0000_0001);
    regWr(12'h820, 32'h3000_0000);
    regAddr = 12'h830;
    ring(BASE_B, 32'd6, 4'hF);
    readChk("R9 new address not live", 12'h830, 0);
    ring(BASE_A, 32'd6, 4'hF);
    readChk("R9 latched window", 12'h830, 32'h0000_0040);
    regWr(12'h830, 32'h0000_0040);
    regWr(12'h828, 32'hFFFF_FFFF);
    regAddr = 12'h830;
    ring(BASE_A, 32'd7, 4'hF);
    ring(BASE_B, 32'd8, 4'hF);
    readChk("R9 window moved", 12'h830, 32'h0000_0100);
    regWr(12'h830, 32'h0000_0100);
    regWr(12'h828, 32'h0);
    regAddr = 12'h830;
    ring(BASE_B, 32'd9, 4'hF);
    readChk("R9 disarmed", 12'h830, 0);
    irqChk("R9 line low", 0);

    curReq = "R11";
    regWr(12'h828, 32'hFFFF_FFFF);
    regAddr = 12'h830;
    ring(BASE_B, 32'd9, 4'hF);
    regAddr = 12'h830; regWrData = 32'h0000_0200; regWrEn = 1'b1;
    inWrAddr = BASE_B; inWrData = 32'd10; inWrBe = 4'hF; inWrEn = 1'b1;
    tick();
    regWrEn = 1'b0; inWrEn = 1'b0;
    readChk("R11 xor then set", 12'h830, 32'h0000_0400);
    irqChk("R11 line high", 1);
    regAddr = 12'h830; regWrData = 32'h0000_0400; regWrEn = 1'b1;
    inWrData = 32'd10; inWrEn = 1'b1;
    tick();
    regWrEn = 1'b0; inWrEn = 1'b0;
    readChk("R11 same vector re-set", 12'h830, 32'h0000_0400);
    regWr(12'h830, 32'h0000_0400);
    irqChk("R11 final clear", 0);

    tick();
    running = 1'b0;
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

endmodule